// File: doc/BRIEF.md
# Three-Channel Interval Timer

The block holds three 16-bit down-counters behind an 8-bit register bus. Each counter has a 16-bit reload value and an 8-bit control register. A counter counts either every cycle of the block clock or rising edges of its own external clock pin. The external pin passes through a synchronizer and an edge detector first. When a counter passes zero it raises its timeout flag in the shared status register and reloads. It can also toggle its output pin. A single interrupt line reports any flag whose timer has its interrupt enabled.

Software uses it as a periodic tick or a square-wave source. It loads a reload value, sets the control bits, and then drops a global hold bit to start all counters together. The counter can instead run as two cascaded 8-bit stages. Timer 3 can put an extra divide-by-8 in front of its count.

Top module: `tri_timer`

## Requirements
- R1: After reset the status register reads 0x00, the interrupt line and all output pins are low, and every counter and reload value is 0xFFFF.
- R2: Control bit 1 set means the timer counts block clock cycles. In plain mode a reload value N gives a timeout every N+1 counted ticks. The first timeout comes N+1 cycles after the clock edge that releases the global hold. A timeout sets status bit k-1 for timer k.
- R3: Control bit 2 set selects cascaded mode: the low byte reloads on each underflow and the timeout period is (high+1)×(low+1) ticks.
- R4: Bit 0 of timer 3's control register divides its tick by 8, so its period is 8 times the unscaled one.
- R5: Control bit 1 clear means the timer counts rising edges of its external clock input.
- R6: Control bit 7 enables the output pin; while it is 0 the pin is low. With the pin enabled and mode field bits 5:3 equal to 0 or 2, the pin toggles at each timeout; other modes do not toggle.
- R7: Status bit 7 and the interrupt line are high exactly when some flag is set with its timer's interrupt enable (control bit 6) set; changing an enable updates the line on the next cycle without any other access.
- R8: Address 0 writes timer 1's control register when bit 0 of timer 2's control register is 1, and timer 3's otherwise; address 1 writes timer 2's control register and reads the status register.
- R9: While bit 0 of timer 1's control register is 1, every counter holds its reload value and does not count; writing that bit from 0 to 1 clears all status flags.
- R10: Address 2k (k=1..3) writes a shared high-byte buffer; address 2k+1 writes the low byte and moves buffer and low byte together into timer k's reload value. Reads of 2k and 2k+1 return the counter's high and low byte.
- R11: A write that changes a timer's clock-source bit loads that counter from its reload value.
- R12: A timer's flag clears on a read of its counter high byte (address 2k) only if the status register was read while that flag was set; otherwise the flag stays.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the internal count clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (drives read side effects) |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current address |
| ext_clk | input | 3 | External clock input per timer |
| tmr_out | output | 3 | Output pin per timer |
| irq | output | 1 | Combined interrupt line |

## Verification
The bench aims at the off-by-one edges of the period. It samples one cycle before and exactly at the expected timeout in plain, cascaded and prescaled modes. A counter that reloaded one tick late, or a cascade that counted high and low bytes as a flat 16-bit value, would miss one of those samples. It reads the counter before and after the status register to probe the two-step flag clear. It also writes the shared control address with the select bit both ways. A design that misrouted that write would release the hold early or never start timer 3. Further checks cover an interrupt enable flipped with a flag already pending, and a high-byte write with no low byte following. Either error leaves the interrupt line or the counter wrong.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CNT_W     = 16;
  localparam int HALF_W    = CNT_W / 2;
  localparam int PRESC_DIV = 8;
  localparam int PRESC_W   = $clog2(PRESC_DIV);

  // control register bit positions
  localparam int B_GRST  = 0;  // timer 1: global hold; timer 2: select; timer 3: prescale
  localparam int B_SRC   = 1;
  localparam int B_DUAL  = 2;
  localparam int B_MODE  = 3;  // 3-bit field at 5:3
  localparam int B_IE    = 6;
  localparam int B_OE    = 7;

  typedef struct packed {
    logic [CNT_W-1:0] nxt;
    logic             expire;
  } step_t;

  // One counted tick: next counter value and whether this tick is a timeout.
  function automatic step_t count_step(input logic [CNT_W-1:0] c,
                                       input logic [CNT_W-1:0] l,
                                       input logic             dual);
    step_t r;
    r.nxt    = c - 1'b1;
    r.expire = 1'b0;
    if (dual) begin
      if (c[HALF_W-1:0] == '0) begin
        r.nxt[HALF_W-1:0] = l[HALF_W-1:0];
        if (c[CNT_W-1:HALF_W] == '0) begin
          r.expire              = 1'b1;
          r.nxt[CNT_W-1:HALF_W] = l[CNT_W-1:HALF_W];
        end else begin
          r.nxt[CNT_W-1:HALF_W] = c[CNT_W-1:HALF_W] - 1'b1;
        end
      end else begin
        r.nxt = {c[CNT_W-1:HALF_W], c[HALF_W-1:0] - 1'b1};
      end
    end else if (c == '0) begin
      r.expire = 1'b1;
      r.nxt    = l;
    end
    return r;
  endfunction
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], din};
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel import tmr_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             presc_en,
  input  logic             hold,
  input  logic             reload,
  input  logic [CNT_W-1:0] latch,
  input  logic             dual,
  input  logic             toggle_mode,
  input  logic             out_en,
  output logic [CNT_W-1:0] cnt,
  output logic             timeout,
  output logic             pin
);
  localparam logic [PRESC_W-1:0] PRESC_MAX = PRESC_W'(PRESC_DIV - 1);

  logic [PRESC_W-1:0] presc_q;
  logic               step;
  step_t              nx;

  always_comb begin
    step    = tick && (!presc_en || presc_q == PRESC_MAX);
    nx      = count_step(cnt, latch, dual);
    timeout = step && !hold && !reload && nx.expire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               presc_q <= '0;
    else if (hold || !presc_en) presc_q <= '0;
    else if (tick)            presc_q <= presc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '1;
    else if (hold || reload) cnt <= latch;
    else if (step)           cnt <= nx.nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        pin <= 1'b0;
    else if (!out_en)                  pin <= 1'b0;
    else if (timeout && toggle_mode)   pin <= ~pin;
  end
endmodule

// File: rtl/tri_timer.sv
module tri_timer import tmr_pkg::*; #(
  parameter int NCH         = 3,
  parameter int SYNC_STAGES = 2,
  localparam int AW         = $clog2(2 * NCH + 2)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic           rd_en,
  input  logic [AW-1:0]  addr,
  input  logic [7:0]     wdata,
  output logic [7:0]     rdata,
  input  logic [NCH-1:0] ext_clk,
  output logic [NCH-1:0] tmr_out,
  output logic           irq
);
  logic [NCH-1:0][7:0]       ctrl_q;
  logic [NCH-1:0][CNT_W-1:0] latch_q;
  logic [NCH-1:0][CNT_W-1:0] cnt;
  logic [7:0]                msb_buf_q;
  logic [NCH-1:0] flag_q, seen_q, tmo, ext_edge, reload, ctrl_we, lat_we, cnt_rd;
  logic [NCH-1:0] ie_vec, oe_vec;
  logic           glb_hold, glb_rise, wr_shared, msb_we, st_rd, comp;

  // ---------------- write / read decode ----------------
  always_comb begin
    wr_shared = wr_en && addr == AW'(0);
    st_rd     = rd_en && addr == AW'(1);
    msb_we    = wr_en && !addr[0] && addr >= AW'(2);
    for (int k = 0; k < NCH; k++) begin
      if (k == 0)            ctrl_we[k] = wr_shared && ctrl_q[1][B_GRST];
      else if (k == NCH - 1) ctrl_we[k] = wr_shared && !ctrl_q[1][B_GRST];
      else                   ctrl_we[k] = wr_en && addr == AW'(1);
      reload[k] = ctrl_we[k] && (wdata[B_SRC] != ctrl_q[k][B_SRC]);
      lat_we[k] = wr_en && addr == AW'(2 * k + 3);
      cnt_rd[k] = rd_en && addr == AW'(2 * k + 2);
      ie_vec[k] = ctrl_q[k][B_IE];
      oe_vec[k] = ctrl_q[k][B_OE];
    end
    glb_hold = ctrl_q[0][B_GRST];
    glb_rise = ctrl_we[0] && wdata[B_GRST] && !ctrl_q[0][B_GRST];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      latch_q   <= '1;
      msb_buf_q <= '0;
    end else begin
      if (msb_we) msb_buf_q <= wdata;
      for (int k = 0; k < NCH; k++) begin
        if (ctrl_we[k]) ctrl_q[k]  <= wdata;
        if (lat_we[k])  latch_q[k] <= {msb_buf_q, wdata};
      end
    end
  end

  // ---------------- status flags ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      seen_q <= '0;
    end else begin
      for (int k = 0; k < NCH; k++) begin
        if (glb_rise) begin
          flag_q[k] <= 1'b0;
          seen_q[k] <= 1'b0;
        end else if (tmo[k]) begin
          flag_q[k] <= 1'b1;
          seen_q[k] <= 1'b0;
        end else if (cnt_rd[k] && seen_q[k]) begin
          flag_q[k] <= 1'b0;
          seen_q[k] <= 1'b0;
        end else if (st_rd && flag_q[k]) begin
          seen_q[k] <= 1'b1;
        end
      end
    end
  end

  assign comp = |(flag_q & ie_vec);
  assign irq  = comp;

  always_comb begin
    rdata = '0;
    if (addr == AW'(1)) rdata = {comp, {(7 - NCH){1'b0}}, flag_q};
    for (int k = 0; k < NCH; k++) begin
      if (addr == AW'(2 * k + 2)) rdata = cnt[k][CNT_W-1:HALF_W];
      if (addr == AW'(2 * k + 3)) rdata = cnt[k][HALF_W-1:0];
    end
  end

  // ---------------- per-timer datapath ----------------
  for (genvar k = 0; k < NCH; k++) begin : g_ch
    logic       tick_raw, presc_sel, toggle_sel;
    logic [2:0] mode;

    tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (ext_clk[k]),
      .rise (ext_edge[k])
    );

    assign tick_raw   = ctrl_q[k][B_SRC] | ext_edge[k];
    assign presc_sel  = (k == NCH - 1) ? ctrl_q[k][B_GRST] : 1'b0;
    assign mode       = ctrl_q[k][B_MODE+2:B_MODE];
    assign toggle_sel = (mode == 3'd0) || (mode == 3'd2);

    tmr_channel u_ch (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick_raw),
      .presc_en   (presc_sel),
      .hold       (glb_hold),
      .reload     (reload[k]),
      .latch      (latch_q[k]),
      .dual       (ctrl_q[k][B_DUAL]),
      .toggle_mode(toggle_sel),
      .out_en     (oe_vec[k]),
      .cnt        (cnt[k]),
      .timeout    (tmo[k]),
      .pin        (tmr_out[k])
    );
  end
endmodule

// File: rtl/tri_timer_chk.sv
module tri_timer_chk #(
  parameter int NCH = 3,
  parameter int W   = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                irq,
  input logic                glb_hold,
  input logic                glb_rise,
  input logic [NCH-1:0]      flags,
  input logic [NCH-1:0]      tmo,
  input logic [NCH-1:0]      oe,
  input logic [NCH-1:0]      pins,
  input logic [NCH-1:0][W-1:0] cnt,
  input logic [NCH-1:0][W-1:0] latch
);
  for (genvar k = 0; k < NCH; k++) begin : g_a
    // R2: a timeout leaves its flag set unless a global hold edge clears it
    a_r2_timeout_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      tmo[k] && !glb_rise |=> flags[k]);
    // R6: pin disabled means pin low one edge later
    a_r6_pin_low_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !oe[k] |=> !pins[k]);
    // R9: hold keeps the counter on its reload value
    a_r9_hold_loads_latch: assert property (@(posedge clk) disable iff (!rst_n)
      glb_hold |=> cnt[k] == $past(latch[k]));
  end

  // R7: interrupt only with a pending flag
  a_r7_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> |flags);
  // R9: asserting global hold clears every flag
  a_r9_rise_clears_flags: assert property (@(posedge clk) disable iff (!rst_n)
    glb_rise |=> flags == '0);
endmodule

bind tri_timer tri_timer_chk #(.NCH(NCH), .W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .irq     (irq),
  .glb_hold(glb_hold),
  .glb_rise(glb_rise),
  .flags   (flag_q),
  .tmo     (tmo),
  .oe      (oe_vec),
  .pins    (tmr_out),
  .cnt     (cnt),
  .latch   (latch_q)
);

// File: tb/tri_timer_test.sv
module tri_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [2:0] ext_clk = '0;
  logic [2:0] tmr_out;
  logic       irq;

  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tri_timer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ext_clk(ext_clk), .tmr_out(tmr_out), .irq(irq)
  );

  // {channel, control, reload, cycles after release, expected flag}
  localparam int NV = 11;
  localparam logic [47:0] VEC [NV] = '{
    {4'd1, 8'h42, 16'h0005, 16'd5,   4'd0},
    {4'd1, 8'h42, 16'h0005, 16'd6,   4'd1},
    {4'd2, 8'h46, 16'h0203, 16'd11,  4'd0},
    {4'd2, 8'h46, 16'h0203, 16'd12,  4'd1},
    {4'd3, 8'h43, 16'h0002, 16'd23,  4'd0},
    {4'd3, 8'h43, 16'h0002, 16'd24,  4'd1},
    {4'd3, 8'h42, 16'h0002, 16'd3,   4'd1},
    {4'd1, 8'h02, 16'h0000, 16'd1,   4'd1},
    {4'd2, 8'h06, 16'h0000, 16'd0,   4'd0},
    {4'd1, 8'h46, 16'h00FF, 16'd255, 4'd0},
    {4'd1, 8'h46, 16'h00FF, 16'd256, 4'd1}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // hold all timers, program timer ch with cfg and reload value
  task automatic setup(input int ch, input logic [7:0] cfg, input logic [15:0] lv);
    wr(3'd1, 8'h01);
    wr(3'd0, (ch == 1) ? (cfg | 8'h01) : 8'h01);
    wr(3'd1, 8'h00);
    wr(3'd0, (ch == 3) ? cfg : 8'h00);
    wr(3'(2 * ch), lv[15:8]);
    wr(3'(2 * ch + 1), lv[7:0]);
    wr(3'd1, ((ch == 2) ? cfg : 8'h00) | 8'h01);
  endtask

  task automatic release_hold(input int ch, input logic [7:0] cfg);
    wr(3'd0, (ch == 1) ? (cfg & 8'hFE) : 8'h00);
  endtask

  task automatic pulse_ext(input int k);
    ext_clk[k] = 1'b1;
    wait_cyc(4);
    ext_clk[k] = 1'b0;
    wait_cyc(4);
  endtask

  initial begin
    logic [7:0] d;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);

    // R1 reset state
    rd(3'd1, d); chk("R1 status", d, 8'h00);
    chk("R1 irq", irq, 1'b0);
    chk("R1 pins", tmr_out, 3'b000);
    rd(3'd2, d); chk("R1 counter1 msb", d, 8'hFF);
    rd(3'd7, d); chk("R1 counter3 lsb", d, 8'hFF);

    // R2 R3 R4 R8: period table
    for (int i = 0; i < NV; i++) begin
      logic [47:0] v;
      int ch;
      logic [7:0] cfg;
      logic exp;
      v = VEC[i];
      ch = int'(v[47:44]);
      cfg = v[43:36];
      exp = v[0];
      setup(ch, cfg, v[35:20]);
      release_hold(ch, cfg);
      wait_cyc(int'(v[19:4]));
      chk("R7 irq (period vector)", irq, exp & cfg[6]);
      rd(3'd1, d);
      chk("R2/R3/R4/R8 timeout flag", d[ch-1], exp);
      chk("R7 composite bit", d[7], exp & cfg[6]);
    end

    // R9 R10: hold and reload value transfer
    setup(1, 8'h02, 16'h1234);
    wait_cyc(40);
    rd(3'd2, d); chk("R9 held msb", d, 8'h12);
    rd(3'd3, d); chk("R9 held lsb", d, 8'h34);
    wr(3'd2, 8'h56);
    wait_cyc(2);
    rd(3'd2, d); chk("R10 msb alone not moved", d, 8'h12);
    wr(3'd3, 8'h78);
    wait_cyc(1);
    rd(3'd2, d); chk("R10 new msb", d, 8'h56);
    rd(3'd3, d); chk("R10 new lsb", d, 8'h78);

    // R6 toggle, then R9 flag clear on hold edge
    setup(1, 8'h82, 16'h0003);
    release_hold(1, 8'h82);
    wait_cyc(3); chk("R6 before first toggle", tmr_out[0], 1'b0);
    wait_cyc(1); chk("R6 first toggle", tmr_out[0], 1'b1);
    wait_cyc(4); chk("R6 second toggle", tmr_out[0], 1'b0);
    rd(3'd1, d); chk("R2 flag before hold", d, 8'h01);
    wr(3'd0, 8'h83);
    rd(3'd1, d); chk("R9 hold edge clears status", d, 8'h00);

    // R6 pin disabled, non-toggle mode, mode 2
    setup(1, 8'h02, 16'h0003); release_hold(1, 8'h02);
    wait_cyc(4); chk("R6 pin off stays low", tmr_out[0], 1'b0);
    setup(1, 8'h8A, 16'h0003); release_hold(1, 8'h8A);
    wait_cyc(4); chk("R6 mode 1 no toggle", tmr_out[0], 1'b0);
    setup(1, 8'h92, 16'h0003); release_hold(1, 8'h92);
    wait_cyc(4); chk("R6 mode 2 toggles", tmr_out[0], 1'b1);

    // R7 enable change with pending flag
    setup(1, 8'h02, 16'h0000); release_hold(1, 8'h02);
    wait_cyc(2); chk("R7 irq masked", irq, 1'b0);
    wr(3'd0, 8'h42); chk("R7 irq on enable", irq, 1'b1);
    rd(3'd1, d); chk("R7 status composite", d, 8'h81);
    wr(3'd0, 8'h02); chk("R7 irq off on disable", irq, 1'b0);

    // R11 R12: source change reload and two-step flag clear
    setup(1, 8'h42, 16'h0100); release_hold(1, 8'h42);
    wait_cyc(257); chk("R2 long period irq", irq, 1'b1);
    wr(3'd0, 8'h40);
    rd(3'd2, d); chk("R11 reload msb", d, 8'h01);
    rd(3'd3, d); chk("R11 reload lsb", d, 8'h00);
    rd(3'd1, d); chk("R12 flag kept without status read", d, 8'h81);
    rd(3'd2, d);
    rd(3'd1, d); chk("R12 flag cleared", d, 8'h00);
    chk("R12 irq cleared", irq, 1'b0);

    // R5 external clock
    setup(2, 8'h40, 16'h0002); release_hold(2, 8'h40);
    pulse_ext(1); pulse_ext(1);
    rd(3'd1, d); chk("R5 two edges no timeout", d[1], 1'b0);
    pulse_ext(1);
    chk("R5 third edge timeout", irq, 1'b1);

    // R8 shared address routed to timer 3 when select is 0
    setup(1, 8'h42, 16'h0005);
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h00);
    wait_cyc(10); chk("R8 timer1 still held", irq, 1'b0);
    wr(3'd1, 8'h01);
    wr(3'd0, 8'h42);
    wait_cyc(6); chk("R8 timer1 runs after release", irq, 1'b1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule